// File: doc/BRIEF.md
# Register-Pointer Serial Slave Interface

This block is the target side of a two-wire serial bus (I2C-compatible) that fronts a small bank of 16-bit registers. It receives SCL and SDA after they have been synchronized and filtered, finds start and stop conditions, checks the address byte, and answers each byte with an acknowledge or a refusal by pulling SDA low or leaving it released. A write-only pointer chooses one of seven registers. A read sends the chosen register upper byte first and keeps cycling through its bytes for as long as the master acknowledges.

The registers themselves live outside the block. The block presents a plain register-file port: a select that always equals the pointer, read data that the environment returns for that select in the same cycle, and write data with a byte strobe. There is no back-pressure on this port. Read data must be valid in every cycle for the current select, and a strobe is a one-cycle pulse that the register file must take at once. A separate one-cycle pulse marks each finished register read, so that neighbouring alarm logic can act on it.

Top module: `regptr_i2c_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) begins address reception from any state. A stop condition (SDA rises while SCL is high) returns the block to idle with SDA released. A repeated start without a stop is accepted.
- R2: The 7-bit address is binary 1001 followed by the three address-pin bits, MSB first, and then a direction bit where 1 means read. On a match the block drives SDA low through the ninth clock. On a mismatch it leaves SDA released and ignores all further bytes until the next start.
- R3: SDA is sampled on SCL rising edges, and every byte is shifted MSB first. The block only begins or ends pulling SDA while SCL is low. The SCL low phase must last at least two clock cycles.
- R4: The only pointer values accepted are 0x00, 0x01, 0x02, 0x03, 0x11, 0x12 and 0x13. Any other byte gets a refusal, leaves the pointer unchanged and makes the block ignore the rest of the transfer.
- R5: In every write transfer, the first byte after the address is taken as a pointer, including a transfer that directly follows a write to the same register.
- R6: The pointer resets to 0x00, the read-only temperature register. It keeps its value across transfers, so a read uses the last pointer that was written.
- R7: A read sends the upper byte and then the lower byte. A master acknowledge after the lower byte starts over with the upper byte. A master refusal after any byte releases SDA and ends the read.
- R8: When the pointer is 0x00, every data byte of a write is refused and no write strobe is issued.
- R9: After the second data byte is acknowledged, the write strobe pulses for one cycle with value 2'b11 (bit 1 upper byte, bit 0 lower byte) and carries {upper, lower}. Any further data byte in the same transfer is refused.
- R10: A write that ends with a stop or a repeated start after only the upper data byte pulses the strobe at 2'b10, and the upper byte sits in bits 15:8 of the write data.
- R11: After the lower byte of a read, the read-done output pulses high for exactly one cycle at the SCL falling edge that ends the master's acknowledge clock. A read that ends after an upper byte does not pulse it.
- R12: Each upper byte sent takes a snapshot of the read data, and the lower byte that follows comes from that snapshot, even if the register changes in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized, filtered serial clock |
| sda_i | input | 1 | Synchronized, filtered serial data (wired-AND bus level) |
| addr_pins_i | input | 3 | Strapped low address bits |
| sda_pull_o | output | 1 | 1 = pull SDA low (drives an open-drain pad) |
| reg_sel_o | output | 5 | Register select, equal to the pointer |
| reg_rdata_i | input | 16 | Contents of the selected register |
| reg_wdata_o | output | 16 | Write data, valid while the strobe is set |
| reg_wstrb_o | output | 2 | Byte write strobe, bit 1 upper, bit 0 lower |
| rd_done_o | output | 1 | One-cycle pulse when a register read completes |

## Verification
The bench builds the block with its default parameters: a 16-bit register width (two bytes per register), device identifier 1001, three address pins tied to 101, and a five-bit pointer. With these values the read wrap-around after two bytes, the upper-only partial write and the full set of legal and illegal pointer codes can all be reached through the bus pins. Tying the pins to a fixed value lets both matching addresses and addresses that differ in a single pin bit be sent.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RX_ACK,
    S_TX,
    S_TX_ACK
  } bus_st_e;

  typedef enum logic [1:0] {
    R_ADDR,
    R_PTR,
    R_DATA,
    R_SINK
  } byte_role_e;

  // Legal pointer codes: 0x00..0x03 and 0x11..0x13.
  function automatic logic ptr_ok(input logic [7:0] b);
    return (b[7:5] == 3'b000) && (b[3:2] == 2'b00) &&
           (!b[4] || (b[1:0] != 2'b00));
  endfunction

  // Pointer 0x00 selects the read-only measurement register.
  function automatic logic ptr_ro(input logic [7:0] b);
    return b == 8'h00;
  endfunction

endpackage

// File: rtl/tsb_edge_det.sv
module tsb_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/tsb_ptr_reg.sv
module tsb_ptr_reg
  import tsb_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       byte_in,
  output logic             accept,
  output logic [PTR_W-1:0] ptr
);
  assign accept = ptr_ok(byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (load && accept)
      ptr <= byte_in[PTR_W-1:0];
  end
endmodule

// File: rtl/tsb_wr_collect.sv
module tsb_wr_collect #(
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [7:0]      byte_in,
  input  logic            flush,
  output logic            last,
  output logic [8*NB-1:0] wdata,
  output logic [NB-1:0]   wstrb
);
  localparam int DW = 8 * NB;
  localparam int CW = $clog2(NB + 1);

  logic [DW-1:0] acc, acc_n;
  logic [NB-1:0] got, got_n;
  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(NB - 1));

  always_comb begin
    acc_n = acc;
    got_n = got;
    for (int k = 0; k < NB; k++) begin
      if (push && (cnt == CW'(k))) begin
        acc_n[8*(NB-1-k) +: 8] = byte_in;
        got_n[NB-1-k]          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      got   <= '0;
      cnt   <= '0;
      wdata <= '0;
      wstrb <= '0;
    end else begin
      wstrb <= '0;
      if (flush) begin
        if ((got != '0) && (cnt != CW'(NB))) begin
          wdata <= acc;
          wstrb <= got;
        end
        acc <= '0;
        got <= '0;
        cnt <= '0;
      end else if (push) begin
        acc <= acc_n;
        got <= got_n;
        cnt <= cnt + CW'(1);
        if (last) begin
          wdata <= acc_n;
          wstrb <= got_n;
        end
      end
    end
  end
endmodule

// File: rtl/regptr_i2c_slave.sv
module regptr_i2c_slave
  import tsb_pkg::*;
#(
  parameter int               PIN_W  = 3,
  parameter logic [6-PIN_W:0] DEV_ID = 4'b1001,
  parameter int               PTR_W  = 5,
  parameter int               DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [PIN_W-1:0]  addr_pins_i,
  output logic              sda_pull_o,
  output logic [PTR_W-1:0]  reg_sel_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [DATA_W/8-1:0] reg_wstrb_o,
  output logic              rd_done_o
);
  localparam int NB   = DATA_W / 8;
  localparam int BI_W = (NB > 1) ? $clog2(NB) : 1;

  bus_st_e     state;
  byte_role_e  role;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic        go_tx;
  logic        mack;
  logic [BI_W-1:0]   byte_idx;
  logic [DATA_W-1:0] snap;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic rx_done, ptr_load, ptr_accept, push, wc_last, addr_hit, tx_last;
  logic [BI_W-1:0] nxt_idx;
  logic [7:0]      nxt_byte, first_byte;

  function automatic logic [7:0] pick(input logic [DATA_W-1:0] w,
                                      input logic [BI_W-1:0]   k);
    logic [DATA_W-1:0] t;
    t = w >> (8 * (NB - 1 - int'(k)));
    return t[7:0];
  endfunction

  tsb_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_i),
    .sda      (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c)
  );

  assign rx_done    = (state == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign ptr_load   = rx_done && (role == R_PTR);
  assign push       = rx_done && (role == R_DATA);
  assign addr_hit   = (shreg[7:1] == {DEV_ID, addr_pins_i});
  assign tx_last    = (byte_idx == BI_W'(NB - 1));
  assign nxt_idx    = byte_idx + BI_W'(1);
  assign nxt_byte   = pick(snap, nxt_idx);
  assign first_byte = pick(reg_rdata_i, '0);

  tsb_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .byte_in (shreg),
    .accept  (ptr_accept),
    .ptr     (reg_sel_o)
  );

  tsb_wr_collect #(.NB(NB)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .byte_in (shreg),
    .flush   (start_c | stop_c),
    .last    (wc_last),
    .wdata   (reg_wdata_o),
    .wstrb   (reg_wstrb_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      role       <= R_ADDR;
      bitcnt     <= '0;
      shreg      <= '0;
      go_tx      <= 1'b0;
      mack       <= 1'b0;
      byte_idx   <= '0;
      snap       <= '0;
      sda_pull_o <= 1'b0;
      rd_done_o  <= 1'b0;
    end else begin
      rd_done_o <= 1'b0;
      if (start_c) begin
        state      <= S_RX;
        role       <= R_ADDR;
        bitcnt     <= '0;
        go_tx      <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        state      <= S_IDLE;
        go_tx      <= 1'b0;
        sda_pull_o <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && (bitcnt != 4'd8)) begin
              shreg  <= {shreg[6:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (rx_done) begin
              bitcnt <= '0;
              case (role)
                R_ADDR: begin
                  if (addr_hit) begin
                    sda_pull_o <= 1'b1;
                    go_tx      <= shreg[0];
                    role       <= R_PTR;
                    state      <= S_RX_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                R_PTR: begin
                  if (ptr_accept) begin
                    sda_pull_o <= 1'b1;
                    role       <= ptr_ro(shreg) ? R_SINK : R_DATA;
                    state      <= S_RX_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                R_DATA: begin
                  sda_pull_o <= 1'b1;
                  if (wc_last) role <= R_SINK;
                  state <= S_RX_ACK;
                end
                default: begin
                  sda_pull_o <= 1'b0;
                  state      <= S_RX_ACK;
                end
              endcase
            end
          end
          S_RX_ACK: begin
            if (scl_fall) begin
              if (go_tx) begin
                go_tx      <= 1'b0;
                snap       <= reg_rdata_i;
                byte_idx   <= '0;
                shreg      <= first_byte;
                sda_pull_o <= ~first_byte[7];
                state      <= S_TX;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                bitcnt     <= '0;
                sda_pull_o <= 1'b0;
                state      <= S_TX_ACK;
              end else begin
                shreg      <= {shreg[6:0], 1'b0};
                sda_pull_o <= ~shreg[6];
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_i;
            end else if (scl_fall) begin
              rd_done_o <= tx_last;
              if (mack) begin
                if (tx_last) begin
                  snap       <= reg_rdata_i;
                  byte_idx   <= '0;
                  shreg      <= first_byte;
                  sda_pull_o <= ~first_byte[7];
                end else begin
                  byte_idx   <= nxt_idx;
                  shreg      <= nxt_byte;
                  sda_pull_o <= ~nxt_byte[7];
                end
                state <= S_TX;
              end else begin
                sda_pull_o <= 1'b0;
                state      <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int PTR_W = 5,
  parameter int NB    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_pull_o,
  input logic [PTR_W-1:0] reg_sel_o,
  input logic [NB-1:0]    reg_wstrb_o,
  input logic             rd_done_o
);
  // R1: a stop seen on the pins leaves SDA released
  p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_o);

  // R3: pulling starts only while SCL is low
  p_pull_start_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R3: pulling ends only while SCL is low
  p_pull_end_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> !scl_i);

  // R4: pointer holds a legal code
  p_ptr_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel_o == PTR_W'(8'h00)) || (reg_sel_o == PTR_W'(8'h01)) ||
    (reg_sel_o == PTR_W'(8'h02)) || (reg_sel_o == PTR_W'(8'h03)) ||
    (reg_sel_o == PTR_W'(8'h11)) || (reg_sel_o == PTR_W'(8'h12)) ||
    (reg_sel_o == PTR_W'(8'h13)));

  // R8: no strobe toward the read-only register
  p_no_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wstrb_o != '0) |-> (reg_sel_o != '0));

  // R9: the strobe lasts one cycle
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wstrb_o != '0) |=> (reg_wstrb_o == '0));

  // R10: any strobe includes the upper byte
  p_strobe_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wstrb_o != '0) |-> reg_wstrb_o[NB-1]);

  // R11: read-done is a single-cycle pulse
  p_rd_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_o |=> !rd_done_o);
endmodule

bind regptr_i2c_slave tsb_checker #(.PTR_W(PTR_W), .NB(NB)) u_tsb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_pull_o  (sda_pull_o),
  .reg_sel_o   (reg_sel_o),
  .reg_wstrb_o (reg_wstrb_o),
  .rd_done_o   (rd_done_o)
);

// File: tb/tb_regptr_i2c_slave.sv
module tb_regptr_i2c_slave;
  localparam int Q = 4;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] AW = {4'b1001, PINS, 1'b0};
  localparam logic [7:0] AR = {4'b1001, PINS, 1'b1};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl, m_sda, sda_line, pull, rd_done;
  logic [4:0]  sel;
  logic [15:0] rdata, wdata;
  logic [1:0]  wstrb;
  logic [15:0] regs [7];
  logic [15:0] em [7];
  logic [15:0] temp_val;
  logic [1:0]  strb_seen;
  int strb_cnt = 0, rdn = 0, bad_edge = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic prev_pull = 1'b0;

  assign sda_line = m_sda & ~pull;

  regptr_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_pins_i(PINS), .sda_pull_o(pull), .reg_sel_o(sel),
    .reg_rdata_i(rdata), .reg_wdata_o(wdata), .reg_wstrb_o(wstrb),
    .rd_done_o(rd_done)
  );

  function automatic int ridx(input logic [4:0] p);
    return p[4] ? 3 + int'(p[1:0]) : int'(p[1:0]);
  endfunction

  function automatic logic [15:0] init_val(input int k);
    return 16'(k * 16'h1357 + 16'h0101);
  endfunction

  assign rdata = (ridx(sel) == 0) ? temp_val : regs[ridx(sel)];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) regs[k] <= init_val(k);
    end else if (wstrb != 2'b00) begin
      if (wstrb[1]) regs[ridx(sel)][15:8] <= wdata[15:8];
      if (wstrb[0]) regs[ridx(sel)][7:0]  <= wdata[7:0];
      strb_seen <= wstrb;
      strb_cnt  <= strb_cnt + 1;
    end
    if (rst_n && rd_done) rdn <= rdn + 1;
  end

  // R3 monitor: SDA pulling may only change while SCL is low
  always @(negedge clk) begin
    if (rst_n && (pull !== prev_pull) && scl) bad_edge <= bad_edge + 1;
    prev_pull <= pull;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(~give_ack);
  endtask

  // write: address, pointer, n data bytes (upper, lower, then 0xEE)
  task automatic do_write(input logic [7:0] p, input int n, input logic [15:0] d,
                          output logic a_adr, output logic a_ptr, output logic [2:0] a_dat);
    logic a;
    a_dat = 3'b000;
    bstart();
    send_byte(AW, a_adr);
    send_byte(p, a_ptr);
    for (int i = 0; i < n; i++) begin
      send_byte((i == 0) ? d[15:8] : (i == 1) ? d[7:0] : 8'hEE, a);
      a_dat[i] = a;
    end
    bstop();
  endtask

  // read n bytes, acknowledging all but the last; first byte in [63:56]
  task automatic do_read(input int n, output logic a_adr, output logic [63:0] v);
    logic [7:0] b;
    v = '0;
    bstart();
    send_byte(AR, a_adr);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      v[63-8*i -: 8] = b;
    end
    bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic aa, ap, a;
    logic [2:0] ad;
    logic [63:0] rv;
    logic [7:0] b0, b1;
    int r0, s0;
    logic [4:0] vp [6];
    void'($urandom(32'd2024));
    vp[0] = 5'h01; vp[1] = 5'h02; vp[2] = 5'h03; vp[3] = 5'h11; vp[4] = 5'h12; vp[5] = 5'h13;
    for (int k = 0; k < 7; k++) em[k] = init_val(k);
    rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; temp_val = 16'hA55A;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    wq();

    // reset state
    chk("R6 reset pointer", 32'(sel), 32'h0);
    chk("R1 reset sda released", 32'(pull), 32'h0);
    chk("R9 reset no strobe", 32'(wstrb), 32'h0);

    // default pointer read of temperature register
    r0 = rdn;
    do_read(2, aa, rv);
    chk("R2 read address ack", 32'(aa), 32'h1);
    chk("R7 R6 temp read", 32'(rv[63:48]), 32'hA55A);
    chk("R11 one completion", 32'(rdn - r0), 32'd1);
    chk("R1 stop releases", 32'(pull), 32'h0);

    // address mismatch in one pin bit
    bstart();
    send_byte({4'b1001, 3'b100, 1'b0}, a);
    chk("R2 mismatch nack", 32'(a), 32'h0);
    send_byte(8'h01, a);
    chk("R2 ignored after mismatch", 32'(a), 32'h0);
    bstop();
    chk("R2 pointer untouched", 32'(sel), 32'h0);

    // full write with a third byte
    s0 = strb_cnt;
    do_write(8'h01, 3, 16'hC3E1, aa, ap, ad);
    chk("R5 pointer ack", 32'(ap), 32'h1);
    chk("R9 data acks", 32'(ad), 32'b011);
    chk("R9 strobe value", 32'(strb_seen), 32'b11);
    chk("R9 one strobe", 32'(strb_cnt - s0), 32'd1);
    chk("R9 register written", 32'(regs[1]), 32'hC3E1);
    em[1] = 16'hC3E1;
    chk("R4 pointer updated", 32'(sel), 32'h01);

    // wrap-around read
    r0 = rdn;
    do_read(5, aa, rv);
    chk("R7 wrap bytes", 32'(rv[63:32]), 32'hC3E1C3E1);
    chk("R7 fifth byte", 32'(rv[31:24]), 32'hC3);
    chk("R11 two completions", 32'(rdn - r0), 32'd2);

    // early refusal after upper byte
    r0 = rdn;
    do_read(1, aa, rv);
    chk("R7 upper only", 32'(rv[63:56]), 32'hC3);
    chk("R11 no completion", 32'(rdn - r0), 32'd0);

    // illegal pointer codes
    foreach (vp[i]) ;
    for (int i = 0; i < 5; i++) begin
      logic [7:0] bad;
      bad = (i == 0) ? 8'h04 : (i == 1) ? 8'h10 : (i == 2) ? 8'h20 : (i == 3) ? 8'h14 : 8'h81;
      s0 = strb_cnt;
      do_write(bad, 2, 16'h5555, aa, ap, ad);
      chk("R4 illegal pointer nack", 32'(ap), 32'h0);
      chk("R4 data ignored", 32'(ad), 32'h0);
      chk("R4 pointer kept", 32'(sel), 32'h01);
      chk("R4 no strobe", 32'(strb_cnt - s0), 32'd0);
    end

    // write toward read-only register
    s0 = strb_cnt;
    do_write(8'h00, 2, 16'h1234, aa, ap, ad);
    chk("R8 pointer ack", 32'(ap), 32'h1);
    chk("R8 data nacks", 32'(ad), 32'b000);
    chk("R8 no strobe", 32'(strb_cnt - s0), 32'd0);
    do_read(2, aa, rv);
    chk("R8 temp unchanged", 32'(rv[63:48]), 32'hA55A);

    // upper-only write ended by stop
    do_write(8'h12, 1, 16'h7700, aa, ap, ad);
    chk("R10 upper ack", 32'(ad), 32'b001);
    chk("R10 strobe upper", 32'(strb_seen), 32'b10);
    em[5] = {8'h77, em[5][7:0]};
    chk("R10 register upper", 32'(regs[5]), 32'(em[5]));

    // upper-only write ended by repeated start, then read back
    bstart();
    send_byte(AW, a);
    send_byte(8'h13, a);
    send_byte(8'h4B, a);
    bstart();
    send_byte(AR, a);
    chk("R1 repeated start ack", 32'(a), 32'h1);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bstop();
    em[6] = {8'h4B, em[6][7:0]};
    chk("R10 R1 repeated start commit", 32'({b0, b1}), 32'(em[6]));

    // pointer-only write then read
    do_write(8'h03, 0, 16'h0, aa, ap, ad);
    do_read(2, aa, rv);
    chk("R6 pointer persists", 32'(rv[63:48]), 32'(em[3]));

    // second write transfer: first byte is a pointer again
    do_write(8'h02, 2, 16'hBEEF, aa, ap, ad);
    em[2] = 16'hBEEF;
    s0 = strb_cnt;
    bstart();
    send_byte(AW, a);
    send_byte(8'h13, a);
    bstop();
    chk("R5 first byte as pointer ack", 32'(a), 32'h1);
    chk("R5 pointer moved", 32'(sel), 32'h13);
    chk("R5 no strobe", 32'(strb_cnt - s0), 32'd0);
    chk("R5 register kept", 32'(regs[2]), 32'hBEEF);

    // snapshot of read data
    do_write(8'h00, 0, 16'h0, aa, ap, ad);
    bstart();
    send_byte(AR, a);
    recv_byte(1'b1, b0);
    temp_val = 16'h1234;
    recv_byte(1'b0, b1);
    bstop();
    chk("R12 snapshot", 32'({b0, b1}), 32'hA55A);
    do_read(2, aa, rv);
    chk("R12 fresh value", 32'(rv[63:48]), 32'h1234);

    // constrained random writes and reads
    for (int it = 0; it < 24; it++) begin
      logic [4:0] p;
      logic [15:0] d;
      int n;
      logic [7:0] expb;
      p = vp[$urandom % 6];
      d = 16'($urandom);
      do_write({3'b000, p}, 2, d, aa, ap, ad);
      chk("R9 random write acks", 32'({aa, ap, ad[1:0]}), 32'b1111);
      em[ridx(p)] = d;
      if (($urandom % 4) == 0) begin
        bstart();
        send_byte({4'b1001, PINS ^ 3'(1 << ($urandom % 3)), 1'b1}, a);
        bstop();
        chk("R2 random mismatch", 32'(a), 32'h0);
      end
      n = 1 + int'($urandom % 5);
      r0 = rdn;
      do_read(n, aa, rv);
      for (int i = 0; i < n; i++) begin
        expb = (i % 2 == 0) ? em[ridx(p)][15:8] : em[ridx(p)][7:0];
        chk("R7 random read byte", 32'(rv[63-8*i -: 8]), 32'(expb));
      end
      chk("R11 random completions", 32'(rdn - r0), 32'(n / 2));
    end

    chk("R3 sda changes with SCL low", 32'(bad_edge), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule